// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block turns a software operating-mode request into a set of enable signals for the clock domains and clock sources of a small microcontroller. The domains are the CPU, the main clock, the subsystem clock and the auxiliary clock. The sources and controls are the frequency-locked-loop control, the DCO clock, the DCO DC generator and the crystal oscillator. There is one active mode and five low-power levels. Each deeper level switches off a superset of what the level above it switches off. The oscillators are not modelled here: each one is represented only by its enable output.

Software writes a 3-bit mode code. While the block sits in a low-power level, a pending interrupt returns it to full activity so the handler can run. The level in force is held in a register. When the handler ends, the interrupt-return strobe reloads that level. A mode write made during servicing replaces the level that the return will restore. All enables come from flip-flops, so they change only on a clock edge.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises, all eight enables read 1 (active mode) until a write or an event changes them.
- R2: Mode code 0 (active) drives every enable to 1. In the bench vector {xtal,dcogen,dcoclk,fll,aclk,smclk,mclk,cpu} with cpu at bit 0, this value is 0xFF.
- R3: Code 1 (level 0) clears cpu and mclk and keeps every other enable at 1: vector 0xFC.
- R4: Code 2 (level 1) clears cpu, mclk and fll and keeps smclk, aclk, dcoclk, dcogen and xtal at 1: vector 0xEC.
- R5: Code 3 (level 2) keeps only aclk, dcogen and xtal at 1: vector 0xC8.
- R6: Code 4 (level 3) keeps only aclk and xtal at 1: vector 0x88.
- R7: Code 5 (level 4) clears all eight enables: vector 0x00.
- R8: Codes 6 and 7 act exactly like code 5.
- R9: When `irq_pend` is high at a clock edge while a low-power level is in force, all enables read 1 after that edge. When the mode is already active, `irq_pend` has no effect.
- R10: An `irq_ret` pulse during servicing restores the stored level's enables at the next edge. An `irq_ret` pulse outside servicing has no effect.
- R11: A mode write during servicing keeps all enables at 1. The written level is the one that `irq_ret` restores.
- R12: A mode write shows on the enables exactly one clock edge after it is sampled. With no write, no `irq_pend` and no `irq_ret`, the enables hold their value.
- R13: The enables always nest. cpu equals mclk. A cleared dcoclk implies a cleared fll. A cleared dcogen implies a cleared dcoclk and smclk. A cleared xtal implies a cleared aclk and dcogen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode code: 0 active, 1..5 levels 0..4, 6 and 7 treated as 5 |
| irq_pend | input | 1 | An interrupt is pending |
| irq_ret | input | 1 | The interrupt handler has returned |
| cpu_en | output | 1 | CPU enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Subsystem clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| fll_en | output | 1 | Frequency-locked-loop control enable |
| dcoclk_en | output | 1 | DCO clock enable |
| dcogen_en | output | 1 | DCO DC generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
A corrupted stored level shows up only on the `irq_ret` edge, as the wrong enable vector. For that reason the bench runs every wake and return sequence from a level it knows, and it includes a write made during servicing. A stuck servicing flag looks like an active mode that never leaves. It is caught one edge after the return strobe. An error in the level decode shows as a broken nesting relation or a wrong vector on the edge after the write. The table walk runs through every code, so such an error cannot stay hidden.

// File: rtl/lpm_pkg.sv
// Shared types and constants for the low-power clock gating controller.
// Assumes eight gated domains in a fixed bit order, cpu at bit 0.
package lpm_pkg;
    localparam int NUM_DOM = 8;
    localparam int LVL_W   = 3;
    // Depth level: 0 = active, 1..5 = low-power levels 0..4
    localparam logic [LVL_W-1:0] LVL_ACTIVE = '0;
    localparam logic [LVL_W-1:0] LVL_DEEP   = 3'd5;

    // Bit positions of the enable vector
    localparam int D_CPU = 0;
    localparam int D_MCLK = 1;
    localparam int D_SMCLK = 2;
    localparam int D_ACLK = 3;
    localparam int D_FLL = 4;
    localparam int D_DCOCLK = 5;
    localparam int D_DCOGEN = 6;
    localparam int D_XTAL = 7;

    // Deepest level at which each domain still runs (enabled while level <= value)
    localparam logic [LVL_W-1:0] DOM_LAST_LVL [NUM_DOM] =
        '{3'd0, 3'd0, 3'd2, 3'd4, 3'd1, 3'd2, 3'd3, 3'd4};

    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [NUM_DOM-1:0] en_vec_t;
endpackage

// File: rtl/lpm_mode_seq.sv
// Mode sequencer: holds the software-requested level and the servicing flag.
// Produces the level that takes effect at the next edge. Codes above the
// deepest level are clamped to it. Reset enters active mode with no servicing.
module lpm_mode_seq
    import lpm_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              irq_pend,
    input  logic              irq_ret,
    output lvl_t              lvl_next
);
    localparam int unsigned MAX_CODE = int'(LVL_DEEP);

    lvl_t mode_q, mode_n;
    logic svc_q, svc_n;
    lvl_t wr_lvl;

    // Clamp the written code to the deepest legal level
    always_comb begin
        if (int'(mode_wdata) > MAX_CODE) wr_lvl = LVL_DEEP;
        else                             wr_lvl = lvl_t'(mode_wdata);
    end

    // Next state: a write updates the stored level; servicing is entered on irq, left on return
    always_comb begin
        mode_n = mode_wr ? wr_lvl : mode_q;
        if (svc_q) svc_n = !irq_ret;
        else       svc_n = irq_pend && (mode_q != LVL_ACTIVE);
        lvl_next = svc_n ? LVL_ACTIVE : mode_n;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LVL_ACTIVE;
            svc_q  <= 1'b0;
        end else begin
            mode_q <= mode_n;
            svc_q  <= svc_n;
        end
    end
endmodule

// File: rtl/lpm_en_decode.sv
// Level decoder: each domain is on while the level is no deeper than its
// last running level. Purely combinational.
module lpm_en_decode
    import lpm_pkg::*;
(
    input  lvl_t    lvl,
    output en_vec_t en
);
    // One comparator per domain
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign en[d] = (lvl <= DOM_LAST_LVL[d]);
    end
endmodule

// File: rtl/lpm_en_reg.sv
// Output register: holds the enable vector and resets to all on.
module lpm_en_reg
    import lpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  en_vec_t en_d,
    output en_vec_t en_q
);
    // Register the decoded enables
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '1;
        else        en_q <= en_d;
    end
endmodule

// File: rtl/lpm_clock_ctrl.sv
// Top of the low-power clock gating controller. Sequencer -> decoder ->
// output register. Every enable changes only on a clock edge.
module lpm_clock_ctrl
    import lpm_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              irq_pend,
    input  logic              irq_ret,
    output logic              cpu_en,
    output logic              mclk_en,
    output logic              smclk_en,
    output logic              aclk_en,
    output logic              fll_en,
    output logic              dcoclk_en,
    output logic              dcogen_en,
    output logic              xtal_en
);
    lvl_t    lvl_next;
    en_vec_t en_d, en_q;

    lpm_mode_seq #(.MODE_W(MODE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .irq_pend(irq_pend), .irq_ret(irq_ret), .lvl_next(lvl_next)
    );

    lpm_en_decode u_dec (.lvl(lvl_next), .en(en_d));

    lpm_en_reg u_reg (.clk(clk), .rst_n(rst_n), .en_d(en_d), .en_q(en_q));

    assign cpu_en    = en_q[D_CPU];
    assign mclk_en   = en_q[D_MCLK];
    assign smclk_en  = en_q[D_SMCLK];
    assign aclk_en   = en_q[D_ACLK];
    assign fll_en    = en_q[D_FLL];
    assign dcoclk_en = en_q[D_DCOCLK];
    assign dcogen_en = en_q[D_DCOGEN];
    assign xtal_en   = en_q[D_XTAL];
endmodule

// File: rtl/lpm_clock_ctrl_chk.sv
// Port-level checker for the low-power clock gating controller.
module lpm_clock_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic       irq_pend,
    input logic       irq_ret,
    input logic [7:0] en
);
    AST_RESET_ALL_ON: assert property (@(posedge clk) !rst_n |=> (en == 8'hFF)); // R1
    AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !en[0]) |=> (en == 8'hFF)); // R9
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wr && !irq_pend && !irq_ret) |=> $stable(en)); // R12
    AST_CPU_MCLK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        en[0] == en[1]); // R13
    AST_NEST_DCO: assert property (@(posedge clk) disable iff (!rst_n)
        !en[5] |-> !en[4]); // R13
    AST_NEST_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en[6] |-> (!en[5] && !en[2])); // R13
    AST_NEST_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        !en[7] |-> (!en[3] && !en[6])); // R13
endmodule

bind lpm_clock_ctrl lpm_clock_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .irq_pend(irq_pend), .irq_ret(irq_ret),
    .en({xtal_en, dcogen_en, dcoclk_en, fll_en, aclk_en, smclk_en, mclk_en, cpu_en})
);

// File: tb/lpm_clock_ctrl_tb.sv
module lpm_clock_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 1'b0;
    logic [2:0] mode_wdata = '0;
    logic irq_pend = 1'b0;
    logic irq_ret = 1'b0;
    logic cpu_en, mclk_en, smclk_en, aclk_en, fll_en, dcoclk_en, dcogen_en, xtal_en;
    logic [7:0] en;
    int checks = 0;
    int fails = 0;

    lpm_clock_ctrl u_dut (.*);

    assign en = {xtal_en, dcogen_en, dcoclk_en, fll_en, aclk_en, smclk_en, mclk_en, cpu_en};

    always #10 clk = ~clk;

    // {code, expected vector}
    localparam logic [10:0] VEC [10] = '{
        {3'd1, 8'hFC}, {3'd2, 8'hEC}, {3'd3, 8'hC8}, {3'd4, 8'h88}, {3'd5, 8'h00},
        {3'd0, 8'hFF}, {3'd6, 8'h00}, {3'd2, 8'hEC}, {3'd7, 8'h00}, {3'd0, 8'hFF}
    };
    localparam string VEC_REQ [10] = '{"R3", "R4", "R5", "R6", "R7", "R2", "R8", "R4", "R8", "R2"};

    task automatic chk(input string req, input logic [7:0] exp);
        checks++;
        if (en !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, en, exp);
        end
    endtask

    task automatic wr(input logic [2:0] code);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = code;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic pend;
        @(negedge clk); irq_pend = 1'b1;
        @(negedge clk); irq_pend = 1'b0;
    endtask

    task automatic ret;
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 8'hFF);

        // Table walk over every mode code
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][10:8]);
            chk(VEC_REQ[i], VEC[i][7:0]);
        end

        // R12: one-edge latency and hold
        wr(3'd3);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = 3'd4;
        #5 chk("R12 before edge", 8'hC8);
        @(negedge clk); mode_wr = 1'b0;
        chk("R12 after edge", 8'h88);
        repeat (4) @(negedge clk);
        chk("R12 hold", 8'h88);

        // R9 wake, R10 restore
        pend();
        chk("R9 wake", 8'hFF);
        repeat (3) @(negedge clk);
        chk("R9 stay awake", 8'hFF);
        ret();
        chk("R10 restore", 8'h88);
        ret();
        chk("R10 stray return ignored", 8'h88);

        // R9: irq while active has no effect; a later return leaves it active
        wr(3'd0);
        pend();
        chk("R9 active irq", 8'hFF);
        wr(3'd1);
        chk("R3 after active irq", 8'hFC);

        // R11: write during servicing replaces the restored level
        wr(3'd5);
        chk("R7", 8'h00);
        pend();
        chk("R9 wake from deepest", 8'hFF);
        wr(3'd2);
        chk("R11 stays active", 8'hFF);
        ret();
        chk("R11 restores written", 8'hEC);

        // R8: clamped code wake and restore
        wr(3'd7);
        pend();
        ret();
        chk("R8 restore clamped", 8'h00);

        // R1: reset from a low-power level
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset from deep", 8'hFF);
        rst_n = 1'b1;
        ret();
        chk("R1 no servicing after reset", 8'hFF);

        finish_run();
    end
endmodule